// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block keeps the interrupt state of a small packet Ethernet controller. An 8-bit status register collects single-cycle event strobes from the rest of the controller. An 8-bit mask register chooses which status bits can raise the one level-sensitive interrupt line. Two status bits do not depend only on strobes. They are also set again on every clock while the transmit queue is empty, or while the transmit-completion queue holds an entry.

Software sees two byte registers: status at address 0 and mask at address 1. A write to address 0 is an acknowledge. It clears the clearable status bits named in the written byte. If that byte has bit 1 set, the block also sends a pop strobe to the transmit-completion queue. A write to address 1 loads the mask. A read of either address returns the registered value one cycle later.

Top module: `irq_status_ctrl`

## Requirements
- R1: When synchronous reset ends, the status register reads 0x04 (only bit 2, transmit empty, set), the mask reads 0x00 and `irq_o` is low.
- R2: `irq_o` is high exactly when the bitwise AND of status and mask is nonzero. It follows a mask write or a status change in the cycle after the clock edge that registers it.
- R3: A high bit k of `evt_i` sets status bit k at the next clock edge. The bit layout is: 7 management, 6 early receive, 5 physical-layer event, 4 receive overrun, 3 allocation done, 2 transmit empty, 1 transmit done, 0 receive.
- R4: While `txq_empty_i` is high, status bit 2 is set at every clock edge, and an acknowledge cannot clear it.
- R5: While `doneq_nonempty_i` is high, status bit 1 is set at every clock edge, and an acknowledge cannot clear it.
- R6: An acknowledge (write to address 0) never clears status bits 5, 3 or 0. The clearable set is the constant 0xD6.
- R7: An acknowledge clears each status bit that is set in both the written byte and 0xD6, provided that bit has no event and no forcing in the same cycle.
- R8: If an event strobe for bit k arrives in the same cycle as an acknowledge that clears bit k, the event wins and bit k is set afterwards.
- R9: `doneq_pop_o` is high, in the same cycle as the write, exactly when an acknowledge has data bit 1 set and `doneq_nonempty_i` is high. It is low for an acknowledge with bit 1 clear, and low when the completion queue is empty.
- R10: A write to address 1 loads the whole byte into the mask register.
- R11: A read with `rd_en_i` high returns, one cycle later with `rd_valid_o` high, the value the addressed register held before that clock edge (address 0 status, address 1 mask). `rd_valid_o` is low in any other cycle.
- R12: Without events, forcing or writes, status and mask keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 8 | One-cycle event strobes, one per status bit |
| txq_empty_i | input | 1 | Transmit queue is empty |
| doneq_nonempty_i | input | 1 | Transmit-completion queue holds an entry |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 acknowledge, 1 mask |
| wr_data_i | input | 8 | Write data byte |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 1 | Read address: 0 status, 1 mask |
| rd_data_o | output | 8 | Read data, one cycle after the strobe |
| rd_valid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Level interrupt request |
| doneq_pop_o | output | 1 | Pop strobe to the transmit-completion queue |

## Verification
A wrong status bit shows on `irq_o` in the cycle after the edge that caused it, once the mask selects that bit. It also shows in the next status read, one cycle after the strobe. A wrong mask shows in the same way through `irq_o` and a mask read. A lost or extra pop has no register behind it, so the checks sample `doneq_pop_o` inside the write cycle itself. The checks on priority and on forcing hold a condition across the acknowledge edge and then read status back right away, so a clear that wins wrongly is seen one cycle later.

// File: rtl/irq_ctl_pkg.sv
// Package: shared constants of the interrupt status controller.
// Assumes an 8-bit register file with two byte addresses.
package irq_ctl_pkg;
    localparam int          REG_W        = 8;
    localparam logic [7:0]  ACK_CLEAR    = 8'hD6;  // bits an acknowledge may clear
    localparam logic [7:0]  STATUS_RST   = 8'h04;  // transmit-empty only
    localparam int          BIT_TX_EMPTY = 2;
    localparam int          BIT_TX_DONE  = 1;
    localparam logic        ADDR_STATUS  = 1'b0;
    localparam logic        ADDR_MASK    = 1'b1;
endpackage

// File: rtl/irq_status_reg.sv
// Module: per-bit status latch. Each bit is set by an event or a force and
// cleared by an acknowledge only where CLEARABLE allows it. Set beats clear.
// Assumes single-cycle strobes and a synchronous active-low reset.
module irq_status_reg #(
    parameter int             W         = 8,
    parameter logic [W-1:0]   CLEARABLE = '1,
    parameter logic [W-1:0]   RST_VAL   = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  set_i,
    input  logic          ack_we_i,
    input  logic [W-1:0]  ack_data_i,
    output logic [W-1:0]  status_o
);
    localparam logic [W-1:0] STICKY = ~CLEARABLE;

    logic [W-1:0] status_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic clr;
        // Clear request for this bit: acknowledge names it and it is clearable.
        always_comb clr = ack_we_i && ack_data_i[i] && CLEARABLE[i];
        // Bit state: reset value, then set priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          status_q[i] <= RST_VAL[i];
            else if (set_i[i])   status_q[i] <= 1'b1;
            else if (clr)        status_q[i] <= 1'b0;
        end
    end

    assign status_o = status_q;

    // A set request always leaves the bit set (R3, R8).
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

    // Bits outside the clearable set never drop on an acknowledge.
    assert_sticky_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we_i |=> ((status_q & $past(status_q) & STICKY) == ($past(status_q) & STICKY)));

    // Without a set or an acknowledge the register holds.
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_we_i && set_i == '0) |=> $stable(status_q));
endmodule

// File: rtl/irq_mask_reg.sv
// Module: interrupt mask register, loaded whole on a write.
// Assumes a synchronous active-low reset that clears it.
module irq_mask_reg #(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  mask_o
);
    logic [W-1:0] mask_q;

    // Mask storage: cleared on reset, loaded on write.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '0;
        else if (we_i) mask_q <= wdata_i;
    end

    assign mask_o = mask_q;

    assert_mask_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mask_q == $past(wdata_i)));
endmodule

// File: rtl/irq_read_port.sv
// Module: registered read mux with one cycle of latency.
// Assumes a one-bit address: 0 status, 1 mask.
module irq_read_port #(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en_i,
    input  logic          rd_addr_i,
    input  logic [W-1:0]  status_i,
    input  logic [W-1:0]  mask_i,
    output logic [W-1:0]  rd_data_o,
    output logic          rd_valid_o
);
    import irq_ctl_pkg::*;

    logic [W-1:0] data_q;
    logic         valid_q;

    // Capture the addressed register and flag validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= rd_en_i;
            if (rd_en_i) data_q <= (rd_addr_i == ADDR_MASK) ? mask_i : status_i;
        end
    end

    assign rd_data_o  = data_q;
    assign rd_valid_o = valid_q;

    assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o);
    assert_no_spurious_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_o);
endmodule

// File: rtl/irq_status_ctrl.sv
// Module: top of the interrupt status controller. Decodes byte writes into an
// acknowledge or a mask load. Forces the two queue-derived status bits.
// Issues the completion-queue pop and drives the level interrupt.
// Assumes event strobes are one cycle wide and queue flags are synchronous.
module irq_status_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] evt_i,
    input  logic       txq_empty_i,
    input  logic       doneq_nonempty_i,
    input  logic       wr_en_i,
    input  logic       wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic       rd_en_i,
    input  logic       rd_addr_i,
    output logic [7:0] rd_data_o,
    output logic       rd_valid_o,
    output logic       irq_o,
    output logic       doneq_pop_o
);
    import irq_ctl_pkg::*;

    logic [REG_W-1:0] force_set;
    logic [REG_W-1:0] set_all;
    logic [REG_W-1:0] status;
    logic [REG_W-1:0] mask;
    logic             ack_we;
    logic             mask_we;

    // Write decode: address 0 acknowledges, address 1 loads the mask.
    always_comb begin
        ack_we  = wr_en_i && (wr_addr_i == ADDR_STATUS);
        mask_we = wr_en_i && (wr_addr_i == ADDR_MASK);
    end

    // Queue-derived set requests merged with the event strobes.
    always_comb begin
        force_set               = '0;
        force_set[BIT_TX_EMPTY] = txq_empty_i;
        force_set[BIT_TX_DONE]  = doneq_nonempty_i;
        set_all                 = evt_i | force_set;
    end

    irq_status_reg #(
        .W         (REG_W),
        .CLEARABLE (ACK_CLEAR),
        .RST_VAL   (STATUS_RST)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_all),
        .ack_we_i   (ack_we),
        .ack_data_i (wr_data_i),
        .status_o   (status)
    );

    irq_mask_reg #(.W(REG_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mask_we),
        .wdata_i (wr_data_i),
        .mask_o  (mask)
    );

    irq_read_port #(.W(REG_W)) u_read (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en_i),
        .rd_addr_i  (rd_addr_i),
        .status_i   (status),
        .mask_i     (mask),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

    // Pop strobe: acknowledge of transmit-done with an entry present.
    always_comb doneq_pop_o = ack_we && wr_data_i[BIT_TX_DONE] && doneq_nonempty_i;

    // Level interrupt from masked status.
    always_comb irq_o = |(status & mask);

    assert_pop_needs_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        doneq_pop_o |-> (doneq_nonempty_i && wr_en_i));
    assert_irq_needs_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mask != '0));
    assert_tx_empty_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
        txq_empty_i |=> status[BIT_TX_EMPTY]);
    assert_tx_done_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        doneq_nonempty_i |=> status[BIT_TX_DONE]);
endmodule

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_i = '0;
    logic       txq_empty_i = 1'b0;
    logic       doneq_nonempty_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       wr_addr_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic       rd_en_i = 1'b0;
    logic       rd_addr_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       rd_valid_o;
    logic       irq_o;
    logic       doneq_pop_o;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_ctrl i_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .txq_empty_i(txq_empty_i),
        .doneq_nonempty_i(doneq_nonempty_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .irq_o(irq_o),
        .doneq_pop_o(doneq_pop_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Read a register: strobe for one cycle, sample after the edge.
    task automatic rd(input logic a, output logic [7:0] d);
        rd_en_i = 1'b1; rd_addr_i = a;
        @(negedge clk);
        rd_en_i = 1'b0;
        check("R11 valid", {7'd0, rd_valid_o}, 8'h01);
        d = rd_data_o;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic pulse(input logic [7:0] e);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset();
        check("R1 irq", {7'd0, irq_o}, 8'h00);
        check("R11 idle valid", {7'd0, rd_valid_o}, 8'h00);
        rd(1'b0, rv); check("R1 status", rv, 8'h04);
        rd(1'b1, rv); check("R1 mask", rv, 8'h00);
    endtask

    task automatic t_events();
        pulse(8'h01);
        rd(1'b0, rv); check("R3 receive", rv, 8'h05);
        pulse(8'h80);
        rd(1'b0, rv); check("R3 management", rv, 8'h85);
        repeat (3) @(negedge clk);
        rd(1'b0, rv); check("R12 hold", rv, 8'h85);
    endtask

    task automatic t_ack();
        wr(1'b0, 8'hFF);
        rd(1'b0, rv); check("R7 ack clears 7 and 2", rv, 8'h01);
        pulse(8'h28);
        wr(1'b0, 8'hFF);
        rd(1'b0, rv); check("R6 sticky 5,3,0", rv, 8'h29);
    endtask

    task automatic t_mask_irq();
        wr(1'b1, 8'h01);
        rd(1'b1, rv); check("R10 mask", rv, 8'h01);
        check("R2 irq on", {7'd0, irq_o}, 8'h01);
        wr(1'b1, 8'h02);
        check("R2 irq off", {7'd0, irq_o}, 8'h00);
        pulse(8'h10);
        wr(1'b1, 8'h10);
        check("R2 irq overrun", {7'd0, irq_o}, 8'h01);
        wr(1'b0, 8'h10);
        check("R2 irq after ack", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_force();
        txq_empty_i = 1'b1;
        @(negedge clk);
        wr(1'b0, 8'h04);
        rd(1'b0, rv); check("R4 forced bit2", rv & 8'h04, 8'h04);
        txq_empty_i = 1'b0;
        wr(1'b0, 8'h04);
        rd(1'b0, rv); check("R4 released bit2", rv & 8'h04, 8'h00);
        wr(1'b1, 8'h02);
        doneq_nonempty_i = 1'b1;
        @(negedge clk);
        check("R5 irq from done", {7'd0, irq_o}, 8'h01);
        wr(1'b0, 8'h02);
        rd(1'b0, rv); check("R5 forced bit1", rv & 8'h02, 8'h02);
    endtask

    task automatic t_pop();
        doneq_nonempty_i = 1'b1;
        wr_en_i = 1'b1; wr_addr_i = 1'b0; wr_data_i = 8'h02;
        #1 check("R9 pop", {7'd0, doneq_pop_o}, 8'h01);
        wr_data_i = 8'h10;
        #1 check("R9 no pop bit1 clear", {7'd0, doneq_pop_o}, 8'h00);
        wr_addr_i = 1'b1; wr_data_i = 8'h02;
        #1 check("R9 no pop mask write", {7'd0, doneq_pop_o}, 8'h00);
        wr_en_i = 1'b0;
        doneq_nonempty_i = 1'b0;
        wr_en_i = 1'b1; wr_addr_i = 1'b0; wr_data_i = 8'h02;
        #1 check("R9 no pop empty", {7'd0, doneq_pop_o}, 8'h00);
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0;
        rd(1'b0, rv); check("R7 bit1 cleared", rv & 8'h02, 8'h00);
    endtask

    task automatic t_prio();
        pulse(8'h10);
        evt_i = 8'h10; wr_en_i = 1'b1; wr_addr_i = 1'b0; wr_data_i = 8'h10;
        @(negedge clk);
        evt_i = '0; wr_en_i = 1'b0; wr_data_i = '0;
        rd(1'b0, rv); check("R8 event wins", rv & 8'h10, 8'h10);
    endtask

    task automatic t_read_old();
        pulse(8'h40);
        rd_en_i = 1'b1; rd_addr_i = 1'b0;
        wr_en_i = 1'b1; wr_addr_i = 1'b0; wr_data_i = 8'h40;
        @(negedge clk);
        rd_en_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
        check("R11 pre-edge value", rd_data_o & 8'h40, 8'h40);
        @(negedge clk);
        check("R11 valid drops", {7'd0, rd_valid_o}, 8'h00);
        rd(1'b0, rv); check("R7 bit6 cleared", rv & 8'h40, 8'h00);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_events();
                t_ack();
                t_mask_irq();
                t_force();
                t_pop();
                t_prio();
                t_read_old();
            end
            begin
                repeat (5000) @(negedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule